// File: doc/BRIEF.md
# Pipeline Mode Arbiter for a Shared Barrel/Fast Pipeline

This controller decides, cycle by cycle, whether a pipeline shared by several hardware threads runs interleaved across all harts (barrel mode) or as a single fast in-order stream for hart 0 alone (fast mode). It watches which harts are parked in wait-for-interrupt, a strobe from the decoder saying the current instruction cannot run in fast mode, and a handshake from the pipeline saying a drain has finished.

The two modes never share the pipeline. When the preferred mode differs from the current one, the controller raises a flush request, drops its mode-valid output and keeps the old mode until the pipeline reports that it is empty. Only then does the new mode take effect. A quiet counter adds hysteresis: fast mode is considered only after a stretch of more than `QUIET_CYCLES` cycles with no unsupported instruction.

Top module: `pipe_mode_ctrl`

## Requirements
- R1: After reset the mode is barrel (`mode_fast`=0), `flush_req`=0, `mode_valid`=1, and the quiet counter is zero, so with all harts idle from reset release `flush_req` first rises at the 66th rising edge after release (default `QUIET_CYCLES`=64).
- R2: Fast mode is never requested while any hart other than hart 0 has its `hart_wfi` bit low; the state of `hart_wfi[0]` has no effect on the decision. In fast mode, a hart other than 0 leaving wait-for-interrupt raises `flush_req` at the next edge.
- R3: An edge that samples `unsup_instr`=1 clears the quiet counter; with other harts idle, the switch to fast is requested exactly at the 66th edge after that edge, and not before.
- R4: In fast mode, `unsup_instr`=1 raises `flush_req` at the next edge for a return to barrel mode.
- R5: While `flush_req` is high, `mode_valid` is low and `mode_fast` keeps its old value for as long as `flush_done` stays low.
- R6: The edge that samples `flush_done`=1 during a flush flips `mode_fast` to the new mode, drops `flush_req` and raises `mode_valid`.
- R7: The target mode is fixed when a flush starts; a change of decision during that flush takes effect only as a new flush, started after the current one completes.
- R8: `flush_done` while no flush is pending has no effect on `mode_fast`, `flush_req` or `mode_valid`.
- R9: The quiet counter saturates once past `QUIET_CYCLES`, so an arbitrarily long quiet period still permits fast mode one edge after the other harts go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hart_wfi | input | NUM_HARTS | Per-hart wait-for-interrupt flags |
| unsup_instr | input | 1 | Decoded instruction cannot run in fast mode |
| flush_done | input | 1 | Pipeline reports the requested drain is complete |
| mode_fast | output | 1 | 1: fast single-hart mode, 0: barrel mode |
| flush_req | output | 1 | Drain request, high until `flush_done` |
| mode_valid | output | 1 | `mode_fast` is in effect (low during a drain) |

## Verification
The bench sweeps the gap after an unsupported instruction from 60 to 70 cycles; an off-by-one in the counter or in the strict comparison would request fast mode one edge early or late. It walks all sixteen wait-for-interrupt patterns on a saturated counter, catching a design that looks at hart 0 or that lets its counter wrap. It injects an unsupported instruction inside a drain toward fast mode; a design that retargets mid-flush would land in barrel mode directly instead of completing the switch and then starting a second flush. Stray `flush_done` pulses outside a drain check that the mode cannot flip on its own.

// File: rtl/pipe_mode_ctrl.sv
module pipe_mode_ctrl #(
  parameter int NUM_HARTS    = 4,
  parameter int QUIET_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HARTS-1:0] hart_wfi,
  input  logic                 unsup_instr,
  input  logic                 flush_done,
  output logic                 mode_fast,
  output logic                 flush_req,
  output logic                 mode_valid
);
  localparam int CW = $clog2(QUIET_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYCLES);
  localparam logic [NUM_HARTS-1:0] HART0_MASK = NUM_HARTS'(1);

  logic [CW-1:0] quiet_cnt;
  logic          flushing;
  logic          target_fast;

  logic others_idle;
  logic quiet_done;
  logic want_fast;

  assign others_idle = &(hart_wfi | HART0_MASK);
  assign quiet_done  = quiet_cnt > LIMIT;
  assign want_fast   = others_idle && quiet_done && !unsup_instr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           quiet_cnt <= '0;
    else if (unsup_instr) quiet_cnt <= '0;
    else if (!quiet_done) quiet_cnt <= quiet_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_fast   <= 1'b0;
      flushing    <= 1'b0;
      target_fast <= 1'b0;
    end else if (flushing) begin
      if (flush_done) begin
        mode_fast <= target_fast;
        flushing  <= 1'b0;
      end
    end else if (want_fast != mode_fast) begin
      flushing    <= 1'b1;
      target_fast <= want_fast;
    end
  end

  assign flush_req  = flushing;
  assign mode_valid = !flushing;
endmodule

module pipe_mode_ctrl_chk #(
  parameter int NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_HARTS-1:0] hart_wfi,
  input logic                 unsup_instr,
  input logic                 flush_done,
  input logic                 mode_fast,
  input logic                 flush_req,
  input logic                 mode_valid
);
  assert_hold_during_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_done |=> flush_req && !mode_valid && $stable(mode_fast));

  assert_switch_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && flush_done |=> mode_valid && !flush_req && (mode_fast != $past(mode_fast)));

  assert_no_stray_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |=> $stable(mode_fast));

  assert_busy_hart_exits_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode_fast && !(&hart_wfi[NUM_HARTS-1:1]) |=> flush_req);

  assert_unsup_exits_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode_fast && unsup_instr |=> flush_req);

  assert_unsup_blocks_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && !mode_fast && unsup_instr |=> !flush_req);
endmodule

bind pipe_mode_ctrl pipe_mode_ctrl_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hart_wfi(hart_wfi), .unsup_instr(unsup_instr),
  .flush_done(flush_done), .mode_fast(mode_fast), .flush_req(flush_req),
  .mode_valid(mode_valid)
);

// File: tb/pipe_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] hart_wfi;
  logic       unsup_instr;
  logic       flush_done;
  logic       mode_fast, flush_req, mode_valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pipe_mode_ctrl #(.NUM_HARTS(4), .QUIET_CYCLES(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .hart_wfi(hart_wfi), .unsup_instr(unsup_instr),
    .flush_done(flush_done), .mode_fast(mode_fast), .flush_req(flush_req),
    .mode_valid(mode_valid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_flush(input string req, input logic new_fast);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk(req, "mode_fast after done", mode_fast, new_fast);
    chk(req, "mode_valid after done", mode_valid, 1'b1);
    chk(req, "flush_req after done", flush_req, 1'b0);
  endtask

  task automatic pulse_unsup();
    unsup_instr = 1'b1;
    tick();
    unsup_instr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hart_wfi = 4'hF; unsup_instr = 1'b0; flush_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "mode_fast reset", mode_fast, 1'b0);
    chk("R1", "flush_req reset", flush_req, 1'b0);
    chk("R1", "mode_valid reset", mode_valid, 1'b1);

    for (int n = 1; n <= 66; n++) begin
      tick();
      chk("R1", "flush_req after reset count", flush_req, n >= 66);
    end
    chk("R5", "mode held at flush start", mode_fast, 1'b0);
    chk("R5", "mode_valid low in flush", mode_valid, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5", "mode held while waiting", mode_fast, 1'b0);
      chk("R5", "flush_req held", flush_req, 1'b1);
    end

    pulse_unsup();
    chk("R7", "mode held despite unsup", mode_fast, 1'b0);
    finish_flush("R7", 1'b1);
    tick();
    chk("R7", "second flush after switch", flush_req, 1'b1);
    chk("R7", "fast held in second flush", mode_fast, 1'b1);
    finish_flush("R6", 1'b0);

    flush_done = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "stray done mode", mode_fast, 1'b0);
      chk("R8", "stray done flush_req", flush_req, 1'b0);
      chk("R8", "stray done valid", mode_valid, 1'b1);
    end
    flush_done = 1'b0;

    for (int g = 60; g <= 70; g++) begin
      pulse_unsup();
      repeat (g) tick();
      chk("R3", $sformatf("gap %0d flush_req", g), flush_req, g >= 66);
      if (g >= 66) begin
        finish_flush("R3", 1'b1);
        pulse_unsup();
        chk("R4", "flush_req on unsup in fast", flush_req, 1'b1);
        chk("R4", "fast held", mode_fast, 1'b1);
        chk("R4", "valid low", mode_valid, 1'b0);
        finish_flush("R4", 1'b0);
      end
    end

    hart_wfi = 4'h0;
    repeat (200) tick();
    chk("R2", "busy harts keep barrel", mode_fast, 1'b0);
    chk("R2", "busy harts no flush", flush_req, 1'b0);

    for (int p = 0; p < 16; p++) begin
      logic exp_fast;
      exp_fast = (p[3:1] == 3'b111);
      hart_wfi = p[3:0];
      tick();
      chk(exp_fast ? "R9" : "R2", $sformatf("wfi %h flush_req", p), flush_req, exp_fast);
      if (exp_fast) begin
        finish_flush("R2", 1'b1);
        hart_wfi = 4'b1101;
        tick();
        chk("R2", "busy hart leaves fast", flush_req, 1'b1);
        finish_flush("R2", 1'b0);
        hart_wfi = 4'h0;
        tick();
      end else begin
        tick();
        chk("R2", $sformatf("wfi %h still barrel", p), mode_fast, 1'b0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule